// File: doc/BRIEF.md
# PCIe MSI Capture Controller

This block sits beside a PCIe root port and turns message-signalled interrupts into one level interrupt for the host CPU. Software programs a 64-bit doorbell address, a 32-bit enable vector and a 32-bit mask vector through a 32-bit register port. A monitor port watches every inbound memory access. A full, aligned 32-bit write that lands on the doorbell address is claimed. Its data is an index that sets one bit of a 32-bit pending vector, provided the matching enable bit is set.

Software reads the pending vector and clears it by writing ones to flip bits. The interrupt output is high while any pending bit is set with its mask bit clear. Reads aimed at the doorbell address are never claimed, and neither is any access while the enable vector is all zero. Such accesses go on downstream as ordinary traffic. The register port reads back combinationally in the same cycle. Writes take effect at the next rising clock edge.

Top module: `msi_catcher`

## Requirements
- R1: After reset the address halves, the enable, mask and pending registers all read 0, `irq` is 0 and no access is claimed.
- R2: Register offsets are 0x820 (address bits 31:0), 0x824 (address bits 63:32), 0x828 (enable), 0x82C (mask) and 0x830 (pending). A write to one address half replaces that half only, and both halves read back as written.
- R3: Enable and mask read back as written. Offsets outside the five registers read 0, and writes to them change no register.
- R4: A claimed write whose data v is below 32 sets pending bit v at the next edge when enable bit v is 1. `mon_claim` is high in the same cycle as the access.
- R5: A claimed write whose data selects an enable bit that is 0 leaves the pending register unchanged.
- R6: While the enable register is all zero, no access is claimed and the pending register does not change.
- R7: A claimed write with data of 32 or more is absorbed and leaves the pending register unchanged, even when its low 5 bits name an enabled vector.
- R8: A read (`mon_write`=0) at the doorbell address is never claimed and has no effect.
- R9: An access whose byte enables are not all four (`mon_be` != 4'b1111), or whose address bits 1:0 are not zero, is never claimed and has no effect.
- R10: A write to the pending register flips every pending bit where the written data has a 1.
- R11: `irq` is 1 exactly when some pending bit is 1 while its mask bit is 0. It is 0 whenever the pending register is zero.
- R12: When a pending-register write and a claimed capture fall in the same cycle, the flip is applied first and the captured bit is then set. The captured bit therefore always ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mon_valid | input | 1 | Monitored inbound access present |
| mon_write | input | 1 | 1 for a write, 0 for a read |
| mon_addr | input | 64 | Byte address of the monitored access |
| mon_be | input | 4 | Byte enables of the monitored access |
| mon_wdata | input | 32 | Write data of the monitored access |
| mon_claim | output | 1 | Access consumed as an interrupt message (not forwarded) |
| irq | output | 1 | Level interrupt toward the host CPU |

## Verification
Software flipping the pending register and an inbound message setting a pending bit can both land on the same clock edge. The bench provokes this by driving a register write to offset 0x830 and a doorbell write in one cycle. In one case the flip targets the very bit being captured, which was already 1. In another the flip clears a different bit. The pending register is then read back, and the result must show the flip applied with the captured bit forced to 1 on top of it.

// File: rtl/msi_catcher.sv
module msi_catcher #(
  parameter int REG_AW = 12,
  parameter int MON_AW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mon_valid,
  input  logic              mon_write,
  input  logic [MON_AW-1:0] mon_addr,
  input  logic [3:0]        mon_be,
  input  logic [31:0]       mon_wdata,
  output logic              mon_claim,
  output logic              irq
);

  localparam int NVEC  = 32;
  localparam int IDX_W = $clog2(NVEC);
  localparam logic [REG_AW-1:0] OFF_ADDR_LO = REG_AW'(12'h820);
  localparam logic [REG_AW-1:0] OFF_ADDR_HI = REG_AW'(12'h824);
  localparam logic [REG_AW-1:0] OFF_ENABLE  = REG_AW'(12'h828);
  localparam logic [REG_AW-1:0] OFF_MASK    = REG_AW'(12'h82C);
  localparam logic [REG_AW-1:0] OFF_PEND    = REG_AW'(12'h830);

  logic [63:0]     door_q;
  logic [NVEC-1:0] en_q, mask_q, pend_q, pend_d, set_vec;
  logic            wr_pend, idx_ok;

  assign wr_pend = reg_wr && (reg_addr == OFF_PEND);

  assign mon_claim = mon_valid && mon_write && (mon_be == 4'b1111) &&
                     (mon_addr[1:0] == 2'b00) &&
                     (64'(mon_addr) == door_q) && (|en_q);

  assign idx_ok  = (mon_wdata[31:IDX_W] == '0);
  assign set_vec = (mon_claim && idx_ok) ?
                   (en_q & (NVEC'(1) << mon_wdata[IDX_W-1:0])) : '0;
  assign pend_d  = (wr_pend ? (pend_q ^ reg_wdata) : pend_q) | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      door_q <= '0;
      en_q   <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (reg_wr && reg_addr == OFF_ADDR_LO) door_q[31:0]  <= reg_wdata;
      if (reg_wr && reg_addr == OFF_ADDR_HI) door_q[63:32] <= reg_wdata;
      if (reg_wr && reg_addr == OFF_ENABLE)  en_q          <= reg_wdata;
      if (reg_wr && reg_addr == OFF_MASK)    mask_q        <= reg_wdata;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_ADDR_LO: reg_rdata = door_q[31:0];
      OFF_ADDR_HI: reg_rdata = door_q[63:32];
      OFF_ENABLE:  reg_rdata = en_q;
      OFF_MASK:    reg_rdata = mask_q;
      OFF_PEND:    reg_rdata = pend_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = |(pend_q & ~mask_q);

  p_capture_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_claim && mon_wdata < 32'(NVEC) && en_q[mon_wdata[IDX_W-1:0]])
    |=> pend_q[$past(mon_wdata[IDX_W-1:0])]);

  p_blocked_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_claim && mon_wdata < 32'(NVEC) && !en_q[mon_wdata[IDX_W-1:0]] && !wr_pend)
    |=> $stable(pend_q));

  p_window_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !mon_claim);

  p_wide_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_claim && mon_wdata >= 32'(NVEC) && !wr_pend) |=> $stable(pend_q));

  p_read_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && !mon_write) |-> !mon_claim);

  p_partial_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && (mon_be != 4'b1111 || mon_addr[1:0] != 2'b00)) |-> !mon_claim);

  p_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !mon_claim) |=> pend_q == ($past(pend_q) ^ $past(reg_wdata)));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq);

endmodule

// File: tb/msi_catcher_tb.sv
module msi_catcher_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mon_valid = 0, mon_write = 0;
  logic [63:0] mon_addr = 0;
  logic [3:0]  mon_be = 0;
  logic [31:0] mon_wdata = 0;
  logic        mon_claim, irq;

  int checks = 0, failures = 0;
  bit done = 0;

  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_req[$];

  localparam logic [11:0] A_LO = 12'h820, A_HI = 12'h824, A_EN = 12'h828,
                          A_MK = 12'h82C, A_PD = 12'h830;
  localparam logic [63:0] DOOR = 64'h0000_0001_FEE0_1000;

  always #10 clk = ~clk;

  msi_catcher u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
    .mon_write(mon_write), .mon_addr(mon_addr), .mon_be(mon_be),
    .mon_wdata(mon_wdata), .mon_claim(mon_claim), .irq(irq));

  task automatic idle_inputs();
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    mon_valid = 0; mon_write = 0; mon_addr = 0; mon_be = 0; mon_wdata = 0;
  endtask

  task automatic push(input int kind, input logic [31:0] exp, input string req);
    q_kind.push_back(kind); q_exp.push_back(exp); q_req.push_back(req);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); idle_inputs();
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); idle_inputs();
    reg_addr = a; push(0, exp, req);
  endtask

  task automatic irq_is(input logic exp, input string req);
    @(negedge clk); idle_inputs();
    push(1, 32'(exp), req);
  endtask

  task automatic msg(input logic [63:0] a, input logic [31:0] d, input logic w,
                     input logic [3:0] be, input logic exp_claim, input string req);
    @(negedge clk); idle_inputs();
    mon_valid = 1; mon_write = w; mon_addr = a; mon_be = be; mon_wdata = d;
    push(2, 32'(exp_claim), req);
  endtask

  task automatic collide(input logic [31:0] flip, input logic [31:0] d, input string req);
    @(negedge clk); idle_inputs();
    reg_wr = 1; reg_addr = A_PD; reg_wdata = flip;
    mon_valid = 1; mon_write = 1; mon_addr = DOOR; mon_be = 4'hF; mon_wdata = d;
    push(2, 32'd1, req);
  endtask

  // scoreboard monitor: compare queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q_kind.size() > 0) begin
        int k;
        logic [31:0] e, act;
        string r;
        k = q_kind.pop_front(); e = q_exp.pop_front(); r = q_req.pop_front();
        case (k)
          0: act = reg_rdata;
          1: act = {31'b0, irq};
          default: act = {31'b0, mon_claim};
        endcase
        checks++;
        if (act !== e) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_LO, 0, "R1"); rd(A_HI, 0, "R1"); rd(A_EN, 0, "R1");
    rd(A_MK, 0, "R1"); rd(A_PD, 0, "R1"); irq_is(0, "R1");
    msg(64'h0, 32'd0, 1, 4'hF, 0, "R1");
    // R2 address halves
    wr(A_LO, 32'hFEE0_0000); wr(A_HI, 32'h0000_0001);
    rd(A_LO, 32'hFEE0_0000, "R2"); rd(A_HI, 32'h0000_0001, "R2");
    wr(A_LO, 32'hFEE0_1000);
    rd(A_HI, 32'h0000_0001, "R2"); rd(A_LO, 32'hFEE0_1000, "R2");
    // R3 unmapped offset
    wr(12'h834, 32'hFFFF_FFFF);
    rd(12'h834, 0, "R3"); rd(A_EN, 0, "R3"); rd(A_MK, 0, "R3"); rd(A_PD, 0, "R3");
    // R6 window closed
    msg(DOOR, 32'd3, 1, 4'hF, 0, "R6");
    rd(A_PD, 0, "R6");
    // enable bits 31,4,3
    wr(A_EN, 32'h8000_0018);
    rd(A_EN, 32'h8000_0018, "R3");
    // R4 capture
    msg(DOOR, 32'd3, 1, 4'hF, 1, "R4");
    rd(A_PD, 32'h0000_0008, "R4"); irq_is(1, "R11");
    // R5 disabled vector
    msg(DOOR, 32'd9, 1, 4'hF, 1, "R5");
    rd(A_PD, 32'h0000_0008, "R5");
    // R7 out-of-range data, low bits name enabled vector 4
    msg(DOOR, 32'h24, 1, 4'hF, 1, "R7");
    rd(A_PD, 32'h0000_0008, "R7");
    // R4 top vector
    msg(DOOR, 32'd31, 1, 4'hF, 1, "R4");
    rd(A_PD, 32'h8000_0008, "R4");
    // R11 masking
    wr(A_MK, 32'h8000_0008);
    rd(A_MK, 32'h8000_0008, "R3"); irq_is(0, "R11");
    wr(A_MK, 32'h0000_0008); irq_is(1, "R11");
    // R8 read at doorbell
    msg(DOOR, 32'd4, 0, 4'hF, 0, "R8");
    rd(A_PD, 32'h8000_0008, "R8");
    // R9 partial bytes and unaligned doorbell
    msg(DOOR, 32'd4, 1, 4'b0011, 0, "R9");
    rd(A_PD, 32'h8000_0008, "R9");
    wr(A_LO, 32'hFEE0_1002);
    msg(64'h0000_0001_FEE0_1002, 32'd4, 1, 4'hF, 0, "R9");
    rd(A_PD, 32'h8000_0008, "R9");
    wr(A_LO, 32'hFEE0_1000);
    // R10 flip
    wr(A_MK, 32'h0);
    wr(A_PD, 32'h8000_0000);
    rd(A_PD, 32'h0000_0008, "R10"); irq_is(1, "R11");
    wr(A_PD, 32'h0000_0008);
    rd(A_PD, 32'h0000_0000, "R10"); irq_is(0, "R11");
    wr(A_PD, 32'h0000_0004);
    rd(A_PD, 32'h0000_0004, "R10"); irq_is(1, "R11");
    // R12 collisions
    collide(32'h0000_0010, 32'd4, "R12");
    rd(A_PD, 32'h0000_0014, "R12");
    collide(32'h0000_0010, 32'd4, "R12");
    rd(A_PD, 32'h0000_0014, "R12");
    collide(32'h0000_0004, 32'd3, "R12");
    rd(A_PD, 32'h0000_0018, "R12");
    // R6 closing window again
    wr(A_EN, 32'h0);
    msg(DOOR, 32'd31, 1, 4'hF, 0, "R6");
    rd(A_PD, 32'h0000_0018, "R6");
    @(negedge clk); idle_inputs();
    repeat (2) @(negedge clk);
    #8;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule